// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

A single direct-memory-access channel engine for fly-by transfers between one peripheral and memory. Software programs a start address, a transfer count and a mode word through a small write port. When the peripheral raises its request, the channel asks the host for the bus. Once the host grants it, the channel drives the acknowledge, the memory address and a pair of strobes for each item. The data itself moves straight between the peripheral and memory and never passes through the block.

Three request policies share one address and count datapath. Single mode moves one item per request and hands the bus back after each one. Block mode runs to completion once it has started. Demand mode runs for as long as the request stays high, and pauses without losing its place when the request drops. A transfer ends on terminal count or on an external end-of-process input. At that point the channel either reloads its start values and stays armed, or masks itself until software writes to it again.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the hold request, acknowledge and all strobes are low, and the channel is masked. A request is ignored until the mask is cleared.
- R2: `wr_sel_i` selects a register. 0 writes the start address, and also loads the current address. 1 writes the count (N-1 for N items), also loads the current count, and clears the mask. 2 writes the mode word. 3 writes the mask from `wr_data_i[0]`.
- R3: An unmasked request raises `hrq_o`. `dack_o` and the strobes are only driven while `hrq_o` and `hlda_i` are both high.
- R4: Mode bits [4:3]=01 select single mode. Exactly one item moves per grant, and `hrq_o` is low for at least one cycle before the next item. In single and demand mode, a request that drops before the grant withdraws `hrq_o`.
- R5: Mode bits [4:3]=10 select block mode. Once `hrq_o` is raised it stays high after the request falls, and items move every granted cycle until terminal count or end of process.
- R6: Mode bits [4:3]=00 select demand mode. Items move while the request is high. A low request releases the bus and keeps the current address and count, so a later request resumes at the next item.
- R7: Each item decrements the current count. The address steps by one: up when mode bit 2 is 0, down when it is 1.
- R8: `tc_o` is high, together with `dack_o`, on the item issued while the current count is zero. A count of N-1 therefore yields exactly N items.
- R9: `eop_i` high during a granted item ends the run after that item.
- R10: With mode bit 1 set, the end of a run reloads the current address and count from the start values and leaves the channel unmasked.
- R11: With mode bit 1 clear, the end of a run masks the channel, and requests are ignored until software clears the mask.
- R12: Mode bit 0 set gives peripheral-to-memory (`mem_wr_o` with `io_rd_o`). Clear gives memory-to-peripheral (`mem_rd_o` with `io_wr_o`). Exactly one pair is active with each `dack_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select |
| wr_data_i | input | WDW | Register write data |
| dreq_i | input | 1 | Peripheral request |
| hlda_i | input | 1 | Host bus grant |
| eop_i | input | 1 | External end of process |
| hrq_o | output | 1 | Host bus hold request |
| dack_o | output | 1 | Peripheral acknowledge, one cycle per item |
| tc_o | output | 1 | Terminal count, on the last item |
| addr_o | output | AW | Memory address of the current item |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | Peripheral read strobe |
| io_wr_o | output | 1 | Peripheral write strobe |

## Verification
The address-step property assumes software does not rewrite the mode or base registers while a run is in progress. The bench writes registers only while the channel is idle. The properties also take `eop_i` to be meaningful only during a granted item. The bench raises it for exactly one item, placed a cycle after the previous acknowledge so that the edge it is sampled on is unambiguous. The host grant is modelled as following `hrq_o` one cycle later and is withheld only in the handshake test.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    XM_DEMAND = 2'b00,
    XM_SINGLE = 2'b01,
    XM_BLOCK  = 2'b10,
    XM_BLOCK2 = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    SEL_BASE_ADDR = 2'd0,
    SEL_BASE_CNT  = 2'd1,
    SEL_MODE      = 2'd2,
    SEL_MASK      = 2'd3
  } reg_sel_e;

  typedef struct packed {
    xfer_mode_e xmode;      // [4:3]
    logic       addr_dec;   // [2]
    logic       auto_init;  // [1]
    logic       to_mem;     // [0]
  } chan_mode_t;

  localparam int MODE_W = $bits(chan_mode_t);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_XFER = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dma_step_reg.sv
module dma_step_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         rld_i,
  input  logic [W-1:0] rld_val_i,
  input  logic         step_i,
  input  logic         dec_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (ld_i)    q_o <= ld_val_i;
    else if (rld_i)   q_o <= rld_val_i;
    else if (step_i)  q_o <= dec_i ? q_o - ONE : q_o + ONE;
  end
endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_chan_pkg::*;
#(
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int WDW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [1:0]     wr_sel_i,
  input  logic [WDW-1:0] wr_data_i,
  input  logic           set_mask_i,
  output logic [AW-1:0]  base_addr_o,
  output logic [CW-1:0]  base_cnt_o,
  output chan_mode_t     mode_o,
  output logic           mask_o,
  output logic           ld_addr_o,
  output logic           ld_cnt_o
);
  logic wr_mode, wr_mask;

  assign ld_addr_o = wr_en_i && (wr_sel_i == SEL_BASE_ADDR);
  assign ld_cnt_o  = wr_en_i && (wr_sel_i == SEL_BASE_CNT);
  assign wr_mode   = wr_en_i && (wr_sel_i == SEL_MODE);
  assign wr_mask   = wr_en_i && (wr_sel_i == SEL_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_o <= '0;
      base_cnt_o  <= '0;
      mode_o      <= '0;
    end else begin
      if (ld_addr_o) base_addr_o <= wr_data_i[AW-1:0];
      if (ld_cnt_o)  base_cnt_o  <= wr_data_i[CW-1:0];
      if (wr_mode)   mode_o      <= chan_mode_t'(wr_data_i[MODE_W-1:0]);
    end
  end

  // software write wins over the end-of-run mask
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mask_o <= 1'b1;
    else if (wr_mask)    mask_o <= wr_data_i[0];
    else if (ld_cnt_o)   mask_o <= 1'b0;
    else if (set_mask_i) mask_o <= 1'b1;
  end
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_chan_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dreq_i,
  input  logic       hlda_i,
  input  logic       eop_i,
  input  logic       mask_i,
  input  xfer_mode_e xmode_i,
  input  logic       cnt_zero_i,
  output logic       hrq_o,
  output logic       xfer_go_o,
  output logic       tc_o,
  output logic       run_end_o
);
  seq_state_e st_q, st_d;
  logic is_demand, is_single, is_block;

  assign is_demand = (xmode_i == XM_DEMAND);
  assign is_single = (xmode_i == XM_SINGLE);
  assign is_block  = xmode_i[1];

  assign hrq_o     = (st_q != ST_IDLE);
  assign xfer_go_o = (st_q == ST_XFER) && hlda_i && (!is_demand || dreq_i);
  assign tc_o      = xfer_go_o && cnt_zero_i;
  assign run_end_o = xfer_go_o && (cnt_zero_i || eop_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (dreq_i && !mask_i) st_d = ST_HOLD;
      ST_HOLD: begin
        if (mask_i)                    st_d = ST_IDLE;
        else if (!is_block && !dreq_i) st_d = ST_IDLE;
        else if (hlda_i)               st_d = ST_XFER;
      end
      ST_XFER: begin
        if (xfer_go_o) begin
          if (run_end_o || is_single) st_d = ST_IDLE;
        end else if (is_demand && !dreq_i) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int WDW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [1:0]     wr_sel_i,
  input  logic [WDW-1:0] wr_data_i,
  input  logic           dreq_i,
  input  logic           hlda_i,
  input  logic           eop_i,
  output logic           hrq_o,
  output logic           dack_o,
  output logic           tc_o,
  output logic [AW-1:0]  addr_o,
  output logic           mem_rd_o,
  output logic           mem_wr_o,
  output logic           io_rd_o,
  output logic           io_wr_o
);
  logic [AW-1:0] base_addr;
  logic [CW-1:0] base_cnt, cur_cnt;
  chan_mode_t    mode_q;
  logic          mask_q, ld_addr, ld_cnt;
  logic          xfer_go, run_end, reload, set_mask, step;
  logic          xfer_single, addr_dec;

  assign xfer_single = (mode_q.xmode == XM_SINGLE);
  assign addr_dec    = mode_q.addr_dec;
  assign reload      = run_end && mode_q.auto_init;
  assign set_mask    = run_end && !mode_q.auto_init;
  assign step        = xfer_go && !reload;

  dma_cfg_regs #(.AW(AW), .CW(CW), .WDW(WDW)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .set_mask_i  (set_mask),
    .base_addr_o (base_addr),
    .base_cnt_o  (base_cnt),
    .mode_o      (mode_q),
    .mask_o      (mask_q),
    .ld_addr_o   (ld_addr),
    .ld_cnt_o    (ld_cnt)
  );

  dma_step_reg #(.W(AW)) u_cur_addr (
    .clk_i, .rst_ni,
    .ld_i      (ld_addr),
    .ld_val_i  (wr_data_i[AW-1:0]),
    .rld_i     (reload),
    .rld_val_i (base_addr),
    .step_i    (step),
    .dec_i     (mode_q.addr_dec),
    .q_o       (addr_o)
  );

  dma_step_reg #(.W(CW)) u_cur_cnt (
    .clk_i, .rst_ni,
    .ld_i      (ld_cnt),
    .ld_val_i  (wr_data_i[CW-1:0]),
    .rld_i     (reload),
    .rld_val_i (base_cnt),
    .step_i    (step),
    .dec_i     (1'b1),
    .q_o       (cur_cnt)
  );

  dma_seq_fsm u_fsm (
    .clk_i, .rst_ni, .dreq_i, .hlda_i, .eop_i,
    .mask_i     (mask_q),
    .xmode_i    (mode_q.xmode),
    .cnt_zero_i (cur_cnt == '0),
    .hrq_o,
    .xfer_go_o  (xfer_go),
    .tc_o,
    .run_end_o  (run_end)
  );

  assign dack_o   = xfer_go;
  assign mem_wr_o = xfer_go &&  mode_q.to_mem;
  assign io_rd_o  = xfer_go &&  mode_q.to_mem;
  assign mem_rd_o = xfer_go && !mode_q.to_mem;
  assign io_wr_o  = xfer_go && !mode_q.to_mem;
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          eop_i,
  input logic          hlda_i,
  input logic          hrq_o,
  input logic          dack_o,
  input logic          tc_o,
  input logic [AW-1:0] addr_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic          io_rd_o,
  input logic          io_wr_o,
  input logic          mask_q,
  input logic          xfer_single,
  input logic          addr_dec
);
  localparam logic [AW-1:0] ONE = AW'(1);

  AST_DACK_NEEDS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> (hrq_o && hlda_i)); // R3
  AST_STROBE_NEEDS_DACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o || io_rd_o || io_wr_o) |-> dack_o); // R12
  AST_STROBE_ONE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> ($countones({mem_rd_o, mem_wr_o, io_rd_o, io_wr_o}) == 2
                && (mem_wr_o == io_rd_o))); // R12
  AST_TC_WITH_DACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> dack_o); // R8
  AST_SINGLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_o && xfer_single) |=> (!dack_o && !hrq_o)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_o && $past(dack_o) && !$past(tc_o) && !$past(eop_i) && !$past(wr_en_i))
      |-> (addr_o == (addr_dec ? $past(addr_o) - ONE : $past(addr_o) + ONE))); // R7
  AST_MASK_HOLDS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hrq_o && mask_q && !wr_en_i) |=> !hrq_o); // R11
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .eop_i, .hlda_i, .hrq_o, .dack_o, .tc_o, .addr_o,
  .mem_rd_o, .mem_wr_o, .io_rd_o, .io_wr_o,
  .mask_q, .xfer_single, .addr_dec
);

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;
  localparam int CLK_P = 10;
  localparam int AW = 16, CW = 16, WDW = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0, dreq_i = 1'b0, hlda_i = 1'b0, eop_i = 1'b0;
  logic [1:0] wr_sel_i = '0;
  logic [WDW-1:0] wr_data_i = '0;
  logic hrq_o, dack_o, tc_o, mem_rd_o, mem_wr_o, io_rd_o, io_wr_o;
  logic [AW-1:0] addr_o;

  always #(CLK_P/2) clk_i = ~clk_i;

  dma_chan_seq #(.AW(AW), .CW(CW), .WDW(WDW)) u_dma_chan_seq (.*);

  typedef struct { logic [AW-1:0] addr; logic tc; logic to_mem; } exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_err = 0, n_dack = 0;
  logic grant_en = 1'b1, done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // host grant follows the hold request one cycle later
  initial forever begin
    @(negedge clk_i);
    hlda_i = grant_en && hrq_o;
  end

  // monitor: pops one expected item per acknowledge
  initial forever begin
    @(negedge clk_i); #2;
    if (rst_ni && dack_o) begin
      n_dack++;
      if (exp_q.size() == 0) chk(0, "R8", "unexpected item at addr", int'(addr_o), 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(addr_o == e.addr, "R7", "addr", int'(addr_o), int'(e.addr));
        chk(tc_o == e.tc, "R8", "tc", int'(tc_o), int'(e.tc));
        chk({mem_wr_o, io_rd_o, mem_rd_o, io_wr_o} == (e.to_mem ? 4'b1100 : 4'b0011),
            "R12", "strobes", int'({mem_wr_o, io_rd_o, mem_rd_o, io_wr_o}),
            e.to_mem ? 'hc : 'h3);
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [WDW-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic logic [WDW-1:0] md(input logic [1:0] xm, input logic dec,
                                        input logic ai, input logic tm);
    return WDW'({xm, dec, ai, tm});
  endfunction

  task automatic push_run(input logic [AW-1:0] a0, input int n, input logic dec,
                          input logic last_tc, input logic tm);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.addr = dec ? a0 - AW'(i) : a0 + AW'(i);
      e.tc = last_tc && (i == n - 1);
      e.to_mem = tm;
      exp_q.push_back(e);
    end
  endtask

  task automatic wait_dacks(input int target);
    for (int i = 0; i < 300 && n_dack < target; i++) begin
      @(negedge clk_i); #3;
    end
  endtask

  task automatic settle(input int k);
    repeat (k) @(negedge clk_i);
    #3;
  endtask

  task automatic pulse_dreq();
    @(negedge clk_i); dreq_i = 1'b1;
    @(negedge clk_i); dreq_i = 1'b0;
  endtask

  task automatic chk_empty(input string req);
    chk(exp_q.size() == 0, req, "items left", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #3;
    chk(!hrq_o && !dack_o && !mem_rd_o && !mem_wr_o, "R1", "idle outputs", int'({hrq_o, dack_o}), 0);
    dreq_i = 1'b1; settle(5);
    chk(!hrq_o, "R1", "masked after reset hrq", int'(hrq_o), 0);
    dreq_i = 1'b0;

    // single, up, peripheral to memory
    wr(2'd2, md(2'b01, 0, 0, 1));
    wr(2'd0, 'h1000);
    wr(2'd1, 3);
    push_run('h1000, 4, 0, 1, 1);
    dreq_i = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      int base;
      base = n_dack;
      wait_dacks(base + 1);
      settle(1);
      chk(!hrq_o, "R4", "bus released after single item", int'(hrq_o), 0);
    end
    settle(10);
    chk(!hrq_o, "R11", "masked after tc hrq", int'(hrq_o), 0);
    chk_empty("R8");
    dreq_i = 1'b0;

    // block, down, memory to peripheral, auto-init, run twice
    wr(2'd2, md(2'b10, 1, 1, 0));
    wr(2'd0, 'h20ff);
    wr(2'd1, 2);
    for (int r = 0; r < 2; r++) begin
      int base;
      base = n_dack;
      push_run('h20ff, 3, 1, 1, 0);
      pulse_dreq();
      wait_dacks(base + 3);
      settle(3);
      chk(!hrq_o, "R5", "block ends at tc", int'(hrq_o), 0);
      chk_empty(r == 0 ? "R5" : "R10");
    end

    // block with external end of process on third item
    wr(2'd2, md(2'b10, 0, 0, 1));
    wr(2'd0, 'h3000);
    wr(2'd1, 9);
    begin
      int base;
      base = n_dack;
      push_run('h3000, 3, 0, 0, 1);
      pulse_dreq();
      wait_dacks(base + 2);
      @(posedge clk_i); #1 eop_i = 1'b1;
      @(posedge clk_i); #1 eop_i = 1'b0;
      settle(3);
      chk(!hrq_o, "R9", "eop ends run", int'(hrq_o), 0);
      chk_empty("R9");
    end
    dreq_i = 1'b1; settle(5);
    chk(!hrq_o, "R11", "masked after eop", int'(hrq_o), 0);
    dreq_i = 1'b0;
    wr(2'd1, 0);
    begin
      int base;
      base = n_dack;
      push_run('h3003, 1, 0, 1, 1);
      pulse_dreq();
      wait_dacks(base + 1);
      settle(3);
      chk_empty("R2");
    end

    // demand, pause and resume
    wr(2'd2, md(2'b00, 0, 0, 1));
    wr(2'd0, 'h4000);
    wr(2'd1, 5);
    begin
      int base;
      base = n_dack;
      push_run('h4000, 2, 0, 0, 1);
      dreq_i = 1'b1;
      wait_dacks(base + 2);
      @(posedge clk_i); #1 dreq_i = 1'b0;
      settle(3);
      chk(!hrq_o, "R6", "demand pause hrq", int'(hrq_o), 0);
      chk_empty("R6");
      push_run('h4002, 4, 0, 1, 1);
      @(negedge clk_i); dreq_i = 1'b1;
      wait_dacks(base + 6);
      @(negedge clk_i); dreq_i = 1'b0;
      settle(3);
      chk_empty("R6");
    end

    // handshake without grant
    grant_en = 1'b0;
    wr(2'd2, md(2'b01, 0, 0, 1));
    wr(2'd0, 'h5000);
    wr(2'd1, 0);
    @(negedge clk_i); dreq_i = 1'b1;
    settle(3);
    chk(hrq_o && !dack_o, "R3", "hrq without dack", int'({hrq_o, dack_o}), 2);
    dreq_i = 1'b0;
    settle(2);
    chk(!hrq_o, "R4", "withdrawn request", int'(hrq_o), 0);
    wr(2'd2, md(2'b10, 0, 0, 1));
    pulse_dreq();
    settle(3);
    chk(hrq_o, "R5", "block hrq held after dreq fell", int'(hrq_o), 1);
    begin
      int base;
      base = n_dack;
      push_run('h5000, 1, 0, 1, 1);
      grant_en = 1'b1;
      wait_dacks(base + 1);
      settle(3);
      chk(!hrq_o, "R5", "hrq after block end", int'(hrq_o), 0);
      chk_empty("R3");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule